// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches thirty-two general-purpose input pins, turns activity on them into per-pin pending flags, and merges every enabled pending flag into a single interrupt request for a host processor. Each pin is configured on its own: it may respond to a level or to an edge. A level pin may be active high or active low. An edge pin may respond to rising edges, falling edges or both, and may either keep a detected event until software clears it or only show it for the cycle in which it is detected.

Software reaches the block through a small 16-bit register bus with an address, a write strobe, write data and combinational read data. Every 32-bit per-pin setting is split into two 16-bit registers: the register at the lower address covers pins 0 to 15, and the one two bytes above it covers pins 16 to 31. Next to the request, the block presents the number of the pending pin that an interrupt handler should serve first, together with a flag that says whether any pin is pending at all.

Top module: `gpi_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0, all enable bits are 0, every pin is a level pin, the polarity bits are 1, the hold bits are 0, and both edge-enable bits are 1. The request is 0 and the winner-valid flag is 0.
- R2: The registers sit at these byte addresses, with the low half (pins 0–15) at the address shown and the high half (pins 16–31) two bytes above it: status 0x08, enable 0x0C, type 0x10, polarity 0x14, hold 0x18, falling-edge enable 0x20, rising-edge enable 0x24. Bit n of a half belongs to pin n of that half. Configuration registers read back what was written. An odd or unmapped address reads as 0.
- R3: Each input passes through two synchronizer flops. A change presented before a clock edge reaches status on the third rising edge after it, and not earlier.
- R4: A type bit of 0 makes the pin level triggered. A polarity bit of 1 makes the high level active, and 0 makes the low level active. While the level is active, status is set again on every cycle, so a clear only takes effect once the input is inactive. The bit then stays set until it is cleared.
- R5: A type bit of 1 makes the pin edge triggered. Edges are found by comparing the synchronized value with its value one cycle earlier. The rising enable alone catches only rising edges, the falling enable alone catches only falling edges, and with both set the pin catches either edge.
- R6: For an edge pin with its hold bit at 1, a detected edge stays in status until software clears it.
- R7: For an edge pin with its hold bit at 0, status follows detection: it is 1 for exactly the one cycle after the edge is seen, and 0 otherwise.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new detection meet on the same edge, the bit stays set.
- R9: The request is registered. It is 1 exactly one cycle after some pin had both its status bit and its enable bit at 1.
- R10: The winner output gives the lowest-numbered pending and enabled pin among pins 0–15. Only when none of those is pending does it give the lowest-numbered pending and enabled pin among pins 16–31. The valid flag is 1 exactly when some pin is pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 32 | Asynchronous general-purpose inputs |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt request, registered |
| win_valid | output | 1 | Some enabled pin is pending |
| win_pin | output | 5 | Number of the pin to serve first |

## Verification
The sensitive overlap is a write-one-to-clear landing on the same clock edge as a new detection for the same pin. The bench provokes it on purpose: it raises a held edge pin and times the clear write so that it is still active on the third edge, then expects the bit to survive. A second run mixes sparse random pin toggles with random register writes, including writes to status while level pins are active. Against a bench-side cycle model, it judges the status read-back, the request and the winner on every cycle.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    localparam int HALF_W  = 16;
    localparam int HALF_IW = $clog2(HALF_W);
    localparam int PIN_N   = 2 * HALF_W;
    localparam int PIN_IW  = $clog2(PIN_N);
    localparam int ADDR_W  = 8;

    // Base addresses of the low halves; the high half sits at base + 2.
    localparam logic [ADDR_W-1:0] RA_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] RA_MASK  = 8'h0C;
    localparam logic [ADDR_W-1:0] RA_KIND  = 8'h10;
    localparam logic [ADDR_W-1:0] RA_POL   = 8'h14;
    localparam logic [ADDR_W-1:0] RA_LATCH = 8'h18;
    localparam logic [ADDR_W-1:0] RA_FALL  = 8'h20;
    localparam logic [ADDR_W-1:0] RA_RISE  = 8'h24;

    typedef struct packed {
        logic [PIN_N-1:0] mask;   // 1 = pin may raise the request
        logic [PIN_N-1:0] kind;   // 1 = edge, 0 = level
        logic [PIN_N-1:0] pol;    // 1 = active high
        logic [PIN_N-1:0] latch;  // 1 = keep edge events
        logic [PIN_N-1:0] fall;   // falling edge enable
        logic [PIN_N-1:0] rise;   // rising edge enable
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        mask: '0, kind: '0, pol: '1, latch: '0, fall: '1, rise: '1
    };

    // Event detection for one pin from its synchronized value now and one cycle ago.
    function automatic logic pin_hit(input logic kind, input logic pol,
                                     input logic rise_en, input logic fall_en,
                                     input logic now, input logic was);
        if (kind)
            return (rise_en & now & ~was) | (fall_en & ~now & was);
        return now == pol;
    endfunction

    // {found, index} of the lowest set bit of a half.
    function automatic logic [HALF_IW:0] first_set(input logic [HALF_W-1:0] v);
        logic [HALF_IW:0] r;
        r = '0;
        for (int i = HALF_W - 1; i >= 0; i--)
            if (v[i]) r = {1'b1, HALF_IW'(i)};
        return r;
    endfunction

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q, cur_q, prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= din;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;
endmodule

// File: rtl/gpi_regs.sv
module gpi_regs
    import gpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [PIN_N-1:0]  stat,
    output pin_cfg_t          cfg,
    output logic [PIN_N-1:0]  clr,
    output logic [HALF_W-1:0] rdata
);
    logic [ADDR_W-1:0] base;
    logic              aligned;
    logic [PIN_IW-1:0] off;
    pin_cfg_t          cfg_q;

    assign base    = {addr[ADDR_W-1:2], 2'b00};
    assign aligned = ~addr[0];
    assign off     = addr[1] ? PIN_IW'(HALF_W) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we && aligned) begin
            case (base)
                RA_MASK:  cfg_q.mask [off +: HALF_W] <= wdata;
                RA_KIND:  cfg_q.kind [off +: HALF_W] <= wdata;
                RA_POL:   cfg_q.pol  [off +: HALF_W] <= wdata;
                RA_LATCH: cfg_q.latch[off +: HALF_W] <= wdata;
                RA_FALL:  cfg_q.fall [off +: HALF_W] <= wdata;
                RA_RISE:  cfg_q.rise [off +: HALF_W] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (we && aligned && base == RA_STAT)
            clr[off +: HALF_W] = wdata;
    end

    always_comb begin
        logic [PIN_N-1:0] sel;
        case (base)
            RA_STAT:  sel = stat;
            RA_MASK:  sel = cfg_q.mask;
            RA_KIND:  sel = cfg_q.kind;
            RA_POL:   sel = cfg_q.pol;
            RA_LATCH: sel = cfg_q.latch;
            RA_FALL:  sel = cfg_q.fall;
            RA_RISE:  sel = cfg_q.rise;
            default:  sel = '0;
        endcase
        rdata = aligned ? sel[off +: HALF_W] : '0;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpi_detect.sv
module gpi_detect
    import gpi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_N-1:0] cur,
    input  logic [PIN_N-1:0] prv,
    input  pin_cfg_t         cfg,
    input  logic [PIN_N-1:0] clr,
    output logic [PIN_N-1:0] stat
);
    logic [PIN_N-1:0] hit;
    logic [PIN_N-1:0] through;
    logic [PIN_N-1:0] stat_q;

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        assign hit[p] = pin_hit(cfg.kind[p], cfg.pol[p], cfg.rise[p],
                                cfg.fall[p], cur[p], prv[p]);
    end

    // Edge pins without hold only show the current detection.
    assign through = cfg.kind & ~cfg.latch;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= hit | (stat_q & ~clr & ~through);
    end

    assign stat = stat_q;
endmodule

// File: rtl/gpi_prio.sv
module gpi_prio
    import gpi_pkg::*;
(
    input  logic [PIN_N-1:0]  pend,
    output logic              valid,
    output logic [PIN_IW-1:0] idx
);
    logic [1:0]         half_hit;
    logic [HALF_IW-1:0] half_idx [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign {half_hit[h], half_idx[h]} = first_set(pend[h*HALF_W +: HALF_W]);
    end

    assign valid = |half_hit;
    assign idx   = half_hit[0] ? {1'b0, half_idx[0]} : {half_hit[1], half_idx[1]};
endmodule

// File: rtl/gpi_irq_ctrl.sv
module gpi_irq_ctrl
    import gpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_N-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              win_valid,
    output logic [PIN_IW-1:0] win_pin
);
    logic [PIN_N-1:0] cur_w, prv_w, stat_w, clr_w;
    pin_cfg_t         cfg_w;
    logic             irq_q;

    gpi_sync #(.W(PIN_N)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .cur(cur_w), .prv(prv_w)
    );

    gpi_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .stat(stat_w), .cfg(cfg_w), .clr(clr_w), .rdata(bus_rdata)
    );

    gpi_detect u_det (
        .clk(clk), .rst(rst), .cur(cur_w), .prv(prv_w), .cfg(cfg_w),
        .clr(clr_w), .stat(stat_w)
    );

    gpi_prio u_prio (
        .pend(stat_w & cfg_w.mask), .valid(win_valid), .idx(win_pin)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(stat_w & cfg_w.mask);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/gpi_irq_ctrl_chk.sv
module gpi_irq_ctrl_chk
    import gpi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_out,
    input logic              win_valid,
    input logic [PIN_IW-1:0] win_pin,
    input logic [PIN_N-1:0]  stat,
    input pin_cfg_t          cfg,
    input logic [PIN_N-1:0]  cur,
    input logic [PIN_N-1:0]  prv
);
    logic [PIN_N-1:0] pend, lvl_on, thru_quiet;

    assign pend       = stat & cfg.mask;
    assign lvl_on     = ~cfg.kind & ~(cur ^ cfg.pol);
    assign thru_quiet = cfg.kind & ~cfg.latch & ~(cur ^ prv);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stat == '0 && !irq_out));

    assert_level_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (|lvl_on) |=> (($past(lvl_on) & ~stat) == '0));

    assert_through_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (|thru_quiet) |=> (($past(thru_quiet) & stat) == '0));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> irq_out);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !irq_out);

    assert_valid_flag_R10: assert property (@(posedge clk) disable iff (rst)
        win_valid == (|pend));

    assert_winner_pending_R10: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> pend[win_pin]);

    assert_winner_lowest_R10: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> ((pend & ((PIN_N'(1) << win_pin) - PIN_N'(1))) == '0));
endmodule

bind gpi_irq_ctrl gpi_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .irq_out(irq_out), .win_valid(win_valid),
    .win_pin(win_pin), .stat(stat_w), .cfg(cfg_w), .cur(cur_w), .prv(prv_w)
);

// File: tb/tb_gpi_irq_ctrl.sv
module tb_gpi_irq_ctrl;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pins;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq_out, win_valid;
    logic [4:0]  win_pin;

    int checks = 0;
    int errors = 0;

    gpi_irq_ctrl dut (
        .clk(clk), .rst(rst), .pin_in(pins), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
        .win_valid(win_valid), .win_pin(win_pin)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Cycle model built from the requirements
    logic [31:0] m_s1, m_s2, m_pv, m_stat;
    logic [31:0] m_en, m_typ, m_pol, m_hold, m_fall, m_rise;
    logic        m_irq;

    always @(posedge clk) begin : model
        logic [31:0] det, clr, thru;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_pv <= 0; m_stat <= 0; m_irq <= 0;
            m_en <= 0; m_typ <= 0; m_pol <= '1; m_hold <= 0; m_fall <= '1; m_rise <= '1;
        end else begin
            clr = 32'h0;
            if (bus_we && bus_addr == 8'h08) clr[15:0]  = bus_wdata;
            if (bus_we && bus_addr == 8'h0A) clr[31:16] = bus_wdata;
            for (int p = 0; p < 32; p++) begin
                if (m_typ[p])
                    det[p] = (m_rise[p] && m_s2[p] && !m_pv[p]) || (m_fall[p] && !m_s2[p] && m_pv[p]);
                else
                    det[p] = (m_s2[p] == m_pol[p]);
            end
            thru   = m_typ & ~m_hold;
            m_irq  <= |(m_stat & m_en);
            m_stat <= det | (m_stat & ~clr & ~thru);
            m_s1 <= pins; m_s2 <= m_s1; m_pv <= m_s2;
            if (bus_we) begin
                case (bus_addr)
                    8'h0C: m_en[15:0]    <= bus_wdata;  8'h0E: m_en[31:16]   <= bus_wdata;
                    8'h10: m_typ[15:0]   <= bus_wdata;  8'h12: m_typ[31:16]  <= bus_wdata;
                    8'h14: m_pol[15:0]   <= bus_wdata;  8'h16: m_pol[31:16]  <= bus_wdata;
                    8'h18: m_hold[15:0]  <= bus_wdata;  8'h1A: m_hold[31:16] <= bus_wdata;
                    8'h20: m_fall[15:0]  <= bus_wdata;  8'h22: m_fall[31:16] <= bus_wdata;
                    8'h24: m_rise[15:0]  <= bus_wdata;  8'h26: m_rise[31:16] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] model_read(input logic [7:0] a);
        logic [31:0] v;
        case ({a[7:2], 2'b00})
            8'h08: v = m_stat;  8'h0C: v = m_en;   8'h10: v = m_typ;
            8'h14: v = m_pol;   8'h18: v = m_hold; 8'h20: v = m_fall;
            8'h24: v = m_rise;  default: v = 32'h0;
        endcase
        if (a[0]) return 16'h0;
        return a[1] ? v[31:16] : v[15:0];
    endfunction

    function automatic logic [5:0] ref_win(input logic [31:0] p);
        for (int i = 0; i < 16; i++) if (p[i]) return {1'b1, 5'(i)};
        for (int i = 16; i < 32; i++) if (p[i]) return {1'b1, 5'(i)};
        return 6'h0;
    endfunction

    function automatic logic [7:0] addr_pick(input int k);
        case (k)
            0: return 8'h08;  1: return 8'h0A;  2: return 8'h0C;  3: return 8'h0E;
            4: return 8'h10;  5: return 8'h12;  6: return 8'h14;  7: return 8'h16;
            8: return 8'h18;  9: return 8'h1A; 10: return 8'h20; 11: return 8'h22;
           12: return 8'h24; default: return 8'h26;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, {16'h0, v}, {16'h0, exp});
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        rst = 1'b1; pins = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rdchk("R1 status lo", 8'h08, 16'h0000);  rdchk("R1 status hi", 8'h0A, 16'h0000);
        rdchk("R1 enable", 8'h0E, 16'h0000);     rdchk("R1 type", 8'h10, 16'h0000);
        rdchk("R1 polarity", 8'h16, 16'hFFFF);   rdchk("R1 hold", 8'h18, 16'h0000);
        rdchk("R1 fall", 8'h22, 16'hFFFF);       rdchk("R1 rise", 8'h24, 16'hFFFF);
        chk("R1 irq", irq_out, 0);               chk("R1 valid", win_valid, 0);

        // R2 map and read-back
        wr(8'h10, 16'h1234); rdchk("R2 type lo readback", 8'h10, 16'h1234);
        wr(8'h1A, 16'hA5A5); rdchk("R2 hold hi readback", 8'h1A, 16'hA5A5);
        rdchk("R2 hold lo untouched", 8'h18, 16'h0000);
        rdchk("R2 unmapped", 8'h00, 16'h0000);   rdchk("R2 odd address", 8'h09, 16'h0000);
        wr(8'h10, 16'h0000); wr(8'h1A, 16'h0000);

        // R3 / R4 / R9 / R10 level pin 3, active high
        wr(8'h0C, 16'h0008);
        pins[3] = 1'b1;
        tick(2); rdchk("R3 not before third edge", 8'h08, 16'h0000);
        tick(1); rdchk("R3 set on third edge", 8'h08, 16'h0008);
        chk("R9 irq one cycle late", irq_out, 0);
        tick(1); chk("R9 irq raised", irq_out, 1);
        chk("R10 valid", win_valid, 1); chk("R10 winner pin3", win_pin, 3);
        wr(8'h08, 16'h0008); rdchk("R4 clear while active ignored", 8'h08, 16'h0008);
        pins[3] = 1'b0;
        tick(3);
        rdchk("R4 level held after inactive", 8'h08, 16'h0008);
        wr(8'h08, 16'h0008); rdchk("R8 clear after inactive", 8'h08, 16'h0000);
        chk("R9 irq still high one cycle", irq_out, 1);
        tick(1); chk("R9 irq dropped", irq_out, 0);

        // R4 active low on pin 5
        wr(8'h14, 16'hFFDF);
        tick(1); rdchk("R4 active low sets", 8'h08, 16'h0020);
        pins[5] = 1'b1;
        tick(3); wr(8'h08, 16'h0020); rdchk("R4 active low cleared when high", 8'h08, 16'h0000);
        wr(8'h14, 16'hFFFF); pins[5] = 1'b0; tick(4); wr(8'h08, 16'hFFFF);

        // R5 / R6 edge pin 20 with hold
        wr(8'h12, 16'h0010); wr(8'h1A, 16'h0010); wr(8'h22, 16'h0000); wr(8'h0A, 16'hFFFF);
        pins[20] = 1'b1; tick(4);
        rdchk("R5 rising caught, R6 held", 8'h0A, 16'h0010);
        wr(8'h0A, 16'h0010); rdchk("R6 cleared, no re-set", 8'h0A, 16'h0000);
        pins[20] = 1'b0; tick(4); rdchk("R5 falling ignored", 8'h0A, 16'h0000);
        wr(8'h22, 16'h0010); wr(8'h26, 16'h0000);
        pins[20] = 1'b1; tick(4); rdchk("R5 rising ignored", 8'h0A, 16'h0000);
        pins[20] = 1'b0; tick(4); rdchk("R5 falling caught", 8'h0A, 16'h0010);
        wr(8'h0A, 16'h0010); wr(8'h26, 16'h0010);
        pins[20] = 1'b1; tick(4); rdchk("R5 both: rising", 8'h0A, 16'h0010);
        wr(8'h0A, 16'h0010);
        pins[20] = 1'b0; tick(4); rdchk("R5 both: falling", 8'h0A, 16'h0010);
        wr(8'h0A, 16'h0010);

        // R7 edge pin 21 without hold
        wr(8'h12, 16'h0030); wr(8'h26, 16'h0030); wr(8'h0E, 16'h0020);
        pins[21] = 1'b1;
        tick(2); rdchk("R7 not yet", 8'h0A, 16'h0000);
        tick(1); rdchk("R7 one-cycle status", 8'h0A, 16'h0020); chk("R9 through irq low", irq_out, 0);
        tick(1); rdchk("R7 status gone", 8'h0A, 16'h0000);      chk("R9 through irq pulse", irq_out, 1);
        tick(1); chk("R9 through irq ends", irq_out, 0);
        pins[21] = 1'b0; tick(4); rdchk("R7 falling disabled", 8'h0A, 16'h0000);
        wr(8'h0E, 16'h0000);

        // R8 clear meets detection on the same edge
        pins[20] = 1'b1;
        tick(2);
        wr(8'h0A, 16'h0010); rdchk("R8 set wins over clear", 8'h0A, 16'h0010);
        wr(8'h0A, 16'h0000); rdchk("R8 zero write no effect", 8'h0A, 16'h0010);
        wr(8'h0A, 16'h0010); rdchk("R8 one write clears", 8'h0A, 16'h0000);

        // R10 priority
        wr(8'h0C, 16'h0006); wr(8'h0E, 16'h0002);
        pins[17] = 1'b1; tick(4); chk("R10 high half winner", win_pin, 17);
        pins[2] = 1'b1; tick(3); chk("R10 low half first", win_pin, 2);
        pins[2] = 1'b0; tick(3); wr(8'h08, 16'h0004); chk("R10 back to high half", win_pin, 17);
        pins[0] = 1'b1; tick(4); rdchk("R10 masked pin pending", 8'h08, 16'h0001);
        chk("R10 masked pin not chosen", win_pin, 17);
        pins = 0; tick(4); wr(8'h08, 16'hFFFF); wr(8'h0A, 16'hFFFF);
        chk("R10 valid clear", win_valid, 0);

        // Random phase against the cycle model (R2 R8 R9 R10)
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] w;
            pins = pins ^ ($urandom & $urandom & $urandom);
            if ($urandom_range(7) == 0) begin
                bus_we = 1'b1; bus_addr = addr_pick($urandom_range(13)); bus_wdata = 16'($urandom);
            end else begin
                bus_we = 1'b0; bus_addr = n[0] ? 8'h0A : 8'h08;
            end
            #1;
            chk("R9 random irq", irq_out, m_irq);
            w = ref_win(m_stat & m_en);
            chk("R10 random valid", win_valid, w[5]);
            if (w[5]) chk("R10 random winner", win_pin, w[4:0]);
            chk("R8 random readback", bus_rdata, model_read(bus_addr));
            @(posedge clk); @(negedge clk);
        end
        bus_we = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule